// File: doc/BRIEF.md
# Thermal Threshold Event and Interrupt Unit

This block watches a stream of filtered temperature codes and turns threshold crossings into sticky event flags and one level-sensitive interrupt. Each sample arrives with a one-cycle valid strobe. On that strobe the sample is compared against a hot limit, a cold limit and a pair of offset limits (high and low). Each crossing sets its own flag. The flags are held until software clears them.

The hot limit is the larger of two programmed hot thresholds, the plain hot value and the normal-to-hot value. A hot crossing always sets two flags together. If the normal-to-hot value has not been programmed, the cold threshold takes its place in that comparison. A sixth flag marks the return from hot: it is set by the first valid sample that is no longer above the hot limit after a sample that was above it.

Software reads the flag word and clears bits by writing ones back. An enable word with the same bit layout as the flags selects which flags drive the interrupt line. How samples are acquired and averaged is outside this block.

Top module: `thermo_trip_unit`

## Requirements
- R1: After reset the flag word `status` is 0 and `irq` is low.
- R2: A valid sample strictly above the hot limit sets flag bit 0 (hot) and flag bit 5 (hot companion) in the same cycle. The hot limit is the larger of `thr_hot` and the effective normal-to-hot value. A sample above `thr_hot` but not above the hot limit sets neither flag.
- R3: When `n2h_prog` is 0, the effective normal-to-hot value is `thr_cold` and `thr_n2h` is ignored. When `n2h_prog` is 1, the effective value is `thr_n2h`.
- R4: A valid sample strictly below `thr_cold` sets flag bit 1 (cold).
- R5: A valid sample strictly above `ofs_high` sets flag bit 2 (high offset).
- R6: A valid sample strictly below `ofs_low` sets flag bit 3 (low offset).
- R7: Flag bit 4 (hot return) is set by a valid sample that is not above the hot limit when the previous valid sample was above it.
- R8: While `smp_valid` is 0, the sample input changes no flag.
- R9: A cycle with `clr_we` high clears every flag whose bit is 1 in `clr_mask`. All other flags keep their value.
- R10: If a flag's event and its clear fall in the same cycle, the flag ends up set.
- R11: `irq` is the OR over all bits of `status` AND `irq_en`, where `irq_en` uses the flag bit layout. It stays high until the enabled flags are cleared or masked.
- R12: A sample exactly equal to a threshold sets none of the flags for that threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_value | input | 12 | Filtered temperature code |
| thr_hot | input | 12 | Hot threshold |
| thr_n2h | input | 12 | Normal-to-hot threshold |
| n2h_prog | input | 1 | 1 when the normal-to-hot threshold is programmed |
| thr_cold | input | 12 | Cold threshold |
| ofs_high | input | 12 | High offset limit |
| ofs_low | input | 12 | Low offset limit |
| irq_en | input | 6 | Interrupt enable per flag |
| clr_we | input | 1 | Write strobe for clear-on-one |
| clr_mask | input | 6 | Flags to clear when `clr_we` is high |
| status | output | 6 | Sticky flag word |
| irq | output | 1 | Level interrupt |

## Verification
A vector table drives samples against several threshold sets. The samples fall between the two hot thresholds, above both, below the cold and low-offset limits, and exactly on each limit. This separates a design that compares against the larger hot threshold from one that uses only `thr_hot`, and strict from inclusive comparisons. Runs with `n2h_prog` low and a large `thr_n2h` show whether the cold threshold really stands in for it. Rising and falling sequences across the hot limit exercise the hot-return flag. Directed steps then cover ignored samples, partial clears, a clear colliding with a new event, enable masking of `irq`, and reset in the middle of a run.

// File: rtl/thermo_trip_pkg.sv
package thermo_trip_pkg;
   localparam int unsigned NUM_FLAGS = 6;
   // Flag bit positions: software decodes these
   localparam int unsigned F_HOT   = 0;
   localparam int unsigned F_COLD  = 1;
   localparam int unsigned F_HOFS  = 2;
   localparam int unsigned F_LOFS  = 3;
   localparam int unsigned F_RET   = 4;
   localparam int unsigned F_HOT2  = 5;
   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/thermo_trip_cmp.sv
module thermo_trip_cmp
   import thermo_trip_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12,
   parameter bit          STRICT   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_value,
   input  logic [SAMPLE_W-1:0] thr_hot,
   input  logic [SAMPLE_W-1:0] thr_n2h,
   input  logic                n2h_prog,
   input  logic [SAMPLE_W-1:0] thr_cold,
   input  logic [SAMPLE_W-1:0] ofs_high,
   input  logic [SAMPLE_W-1:0] ofs_low,
   output flag_vec_t           evt
);
   if (SAMPLE_W < 2 || SAMPLE_W > 32) begin : g_bad_width
      $error("thermo_trip_cmp: SAMPLE_W out of range");
   end

   logic [SAMPLE_W-1:0] n2h_eff;
   logic [SAMPLE_W-1:0] hot_lim;
   logic                above_hot, below_cold, above_ofs, below_ofs;
   logic                was_hot_q;

   // unprogrammed normal-to-hot value falls back to the cold threshold (R3)
   assign n2h_eff = n2h_prog ? thr_n2h : thr_cold;
   assign hot_lim = (thr_hot > n2h_eff) ? thr_hot : n2h_eff;

   if (STRICT) begin : g_strict
      assign above_hot  = smp_value > hot_lim;
      assign below_cold = smp_value < thr_cold;
      assign above_ofs  = smp_value > ofs_high;
      assign below_ofs  = smp_value < ofs_low;
   end else begin : g_inclusive
      assign above_hot  = smp_value >= hot_lim;
      assign below_cold = smp_value <= thr_cold;
      assign above_ofs  = smp_value >= ofs_high;
      assign below_ofs  = smp_value <= ofs_low;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         was_hot_q <= 1'b0;
      else if (smp_valid) was_hot_q <= above_hot;
   end

   always_comb begin
      evt         = '0;
      evt[F_HOT]  = smp_valid & above_hot;
      evt[F_HOT2] = smp_valid & above_hot;
      evt[F_COLD] = smp_valid & below_cold;
      evt[F_HOFS] = smp_valid & above_ofs;
      evt[F_LOFS] = smp_valid & below_ofs;
      evt[F_RET]  = smp_valid & was_hot_q & ~above_hot;
   end

   AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> (evt == '0)); // R8

   AST_RET_NEEDS_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      evt[F_RET] |-> !evt[F_HOT]); // R7
endmodule

// File: rtl/thermo_trip_stat.sv
module thermo_trip_stat
   import thermo_trip_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  flag_vec_t evt,
   input  logic      clr_we,
   input  flag_vec_t clr_mask,
   output flag_vec_t stat_q
);
   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic clr_i;
      assign clr_i = clr_we & clr_mask[i];

      // a new event outranks a clear landing in the same cycle (R10)
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stat_q[i] <= 1'b0;
         else if (evt[i]) stat_q[i] <= 1'b1;
         else if (clr_i)  stat_q[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> stat_q[i]); // R10

      AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !evt[i]) |=> !stat_q[i]); // R9

      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i && !evt[i]) |=> (stat_q[i] == $past(stat_q[i]))); // R9
   end
endmodule

// File: rtl/thermo_trip_gate.sv
module thermo_trip_gate
   import thermo_trip_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  flag_vec_t stat_q,
   input  flag_vec_t irq_en,
   output logic      irq
);
   logic any_hit;
   assign any_hit = |(stat_q & irq_en);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_hit;
      end
      assign irq = irq_q;

      AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_q & irq_en) == '0) |=> !irq); // R11
   end else begin : g_comb
      assign irq = any_hit;

      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_q & irq_en) == '0) |-> !irq); // R11
   end
endmodule

// File: rtl/thermo_trip_unit.sv
module thermo_trip_unit
   import thermo_trip_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12,
   parameter bit          STRICT   = 1'b1,
   parameter bit          REG_IRQ  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_value,
   input  logic [SAMPLE_W-1:0] thr_hot,
   input  logic [SAMPLE_W-1:0] thr_n2h,
   input  logic                n2h_prog,
   input  logic [SAMPLE_W-1:0] thr_cold,
   input  logic [SAMPLE_W-1:0] ofs_high,
   input  logic [SAMPLE_W-1:0] ofs_low,
   input  logic [5:0]          irq_en,
   input  logic                clr_we,
   input  logic [5:0]          clr_mask,
   output logic [5:0]          status,
   output logic                irq
);
   if (NUM_FLAGS != 6) begin : g_bad_flags
      $error("thermo_trip_unit: port width assumes six flags");
   end

   flag_vec_t evt;
   flag_vec_t stat_q;

   thermo_trip_cmp #(.SAMPLE_W(SAMPLE_W), .STRICT(STRICT)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_value (smp_value),
      .thr_hot   (thr_hot),
      .thr_n2h   (thr_n2h),
      .n2h_prog  (n2h_prog),
      .thr_cold  (thr_cold),
      .ofs_high  (ofs_high),
      .ofs_low   (ofs_low),
      .evt       (evt)
   );

   thermo_trip_stat u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_we   (clr_we),
      .clr_mask (clr_mask),
      .stat_q   (stat_q)
   );

   thermo_trip_gate #(.REG_OUT(REG_IRQ)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_q (stat_q),
      .irq_en (irq_en),
      .irq    (irq)
   );

   assign status = stat_q;

   if (STRICT) begin : g_port_checks
      AST_HOT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_valid && smp_value > thr_hot && smp_value > thr_n2h && n2h_prog)
         |=> (status[F_HOT] && status[F_HOT2])); // R2

      AST_COLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_valid && smp_value < thr_cold) |=> status[F_COLD]); // R4

      AST_HOFS_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_valid && smp_value > ofs_high) |=> status[F_HOFS]); // R5

      AST_LOFS_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_valid && smp_value < ofs_low) |=> status[F_LOFS]); // R6
   end
endmodule

// File: tb/thermo_trip_unit_bench.sv
module thermo_trip_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_value = '0;
   logic [11:0] thr_hot = '0, thr_n2h = '0, thr_cold = '0, ofs_high = '0, ofs_low = '0;
   logic        n2h_prog = 1'b0;
   logic [5:0]  irq_en = '0;
   logic        clr_we = 1'b0;
   logic [5:0]  clr_mask = '0;
   logic [5:0]  status;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   thermo_trip_unit u_thermo_trip_unit (
      .clk, .rst_n, .smp_valid, .smp_value, .thr_hot, .thr_n2h, .n2h_prog,
      .thr_cold, .ofs_high, .ofs_low, .irq_en, .clr_we, .clr_mask, .status, .irq
   );

   // {sample, hot, n2h, n2h_prog, cold, ofs_high, ofs_low, expected status}
   localparam int NV = 11;
   localparam logic [78:0] VEC [NV] = '{
      {12'h500, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h100, 6'h00}, // R2 none
      {12'h950, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h100, 6'h21}, // R2 hot pair
      {12'h850, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h100, 6'h10}, // R2/R7 larger limit, return
      {12'hB00, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h100, 6'h25}, // R5
      {12'h080, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h100, 6'h1A}, // R4 R6 R7
      {12'h600, 12'h300, 12'h900, 1'b0, 12'h700, 12'hA00, 12'h100, 6'h02}, // R3 cold stands in
      {12'h750, 12'h300, 12'h900, 1'b0, 12'h700, 12'hA00, 12'h100, 6'h21}, // R3 hot via cold
      {12'h750, 12'h300, 12'h900, 1'b1, 12'h700, 12'hA00, 12'h100, 6'h10}, // R3 programmed
      {12'h900, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h100, 6'h00}, // R12 on hot
      {12'h200, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h200, 6'h00}, // R12 on cold/low
      {12'hA00, 12'h800, 12'h900, 1'b1, 12'h200, 12'hA00, 12'h100, 6'h21}  // R12 on high ofs
   };

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive on negedge, let one posedge capture, return at the next negedge
   task automatic step(input logic v, input logic cw, input logic [5:0] cm);
      smp_valid = v;
      clr_we    = cw;
      clr_mask  = cm;
      @(negedge clk);
      smp_valid = 1'b0;
      clr_we    = 1'b0;
      clr_mask  = '0;
   endtask

   task automatic set_defaults(input logic [11:0] s);
      smp_value = s; thr_hot = 12'h800; thr_n2h = 12'h900; n2h_prog = 1'b1;
      thr_cold = 12'h200; ofs_high = 12'hA00; ofs_low = 12'h100;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 status", status, 6'h00);
      check("R1 irq", {5'd0, irq}, 6'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // table: each vector also clears all old flags, so set-wins keeps only new ones (R10)
      for (int k = 0; k < NV; k++) begin
         {smp_value, thr_hot, thr_n2h, n2h_prog, thr_cold, ofs_high, ofs_low} = VEC[k][78:6];
         step(1'b1, 1'b1, 6'h3F);
         check($sformatf("R2-table vec%0d", k), status, VEC[k][5:0]);
      end

      // R8: strobe low, hot sample present
      step(1'b0, 1'b1, 6'h3F);
      check("R9 clear all", status, 6'h00);
      set_defaults(12'hF00);
      step(1'b0, 1'b0, 6'h00);
      check("R8 idle sample", status, 6'h00);
      irq_en = 6'h3F;
      #1 check("R8 irq idle", {5'd0, irq}, 6'h00);

      // R9 partial clear; previous valid sample was hot so return flag fires
      irq_en = 6'h00;
      set_defaults(12'h080);
      step(1'b1, 1'b0, 6'h00);
      check("R7 return on cold", status, 6'h1A);
      step(1'b0, 1'b1, 6'h08);
      check("R9 partial clear", status, 6'h12);

      // R11 interrupt gating
      irq_en = 6'h01; #1 check("R11 masked", {5'd0, irq}, 6'h00);
      irq_en = 6'h02; #1 check("R11 enabled", {5'd0, irq}, 6'h01);
      step(1'b0, 1'b0, 6'h00);
      check("R11 level held", {5'd0, irq}, 6'h01);
      step(1'b0, 1'b1, 6'h02);
      check("R11 cleared", {5'd0, irq}, 6'h00);
      check("R9 other kept", status, 6'h10);
      irq_en = 6'h10; #1 check("R11 bit4 enable", {5'd0, irq}, 6'h01);

      // R10 collision: cold event and its clear together
      set_defaults(12'h080);
      step(1'b1, 1'b1, 6'h02);
      check("R10 set wins", status, 6'h1A);

      // R1 reset mid-run
      rst_n = 1'b0;
      #1 check("R1 reset status", status, 6'h00);
      check("R1 reset irq", {5'd0, irq}, 6'h00);
      @(negedge clk);
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule